// File: doc/BRIEF.md
# Primitive Run Compressor and Expander

This block sits on the 32-bit dword stream between a serial link layer and its PHY and works in both directions. On transmit it watches the dwords the link layer wants to send. Once one primitive has gone out several times in a row, it sends a single continuation marker. Further copies of that primitive are then replaced by pseudo-random filler dwords. This lowers the spectral energy of long idle runs. On receive it undoes the change. A continuation marker is turned back into the most recent real primitive, and filler dwords that follow it are dropped.

Each dword carries a 4-bit K-flag. A dword is a primitive exactly when its K-flag is 4'b0001. Each direction is one register stage deep. Reset is synchronous and active high. The transmit stream has no valid qualifier, so every cycle carries a dword. The receive stream has a valid qualifier on each side.

Top module: `prim_run_codec`

## Requirements
- R1: While `rst` is high, the transmit output is data 0 with K-flag 0, and `rx_out_valid` is 0.
- R2: A transmit dword that does not complete a repeat run appears unchanged on the transmit output exactly one cycle later.
- R3: If the previous three transmit inputs were the same primitive and the current input equals them, and no run is active yet, the output one cycle later is the continuation marker: data 32'h9999AA7C, K-flag 4'b0001.
- R4: While a run stays active, each further equal input is replaced by a filler dword with K-flag 0. The first filler of a run equals `FILL_SEED`. Each later filler is the previous one shifted right by one bit, XORed with `FILL_POLY` when the bit shifted out was 1.
- R5: The first input that breaks a run passes through unchanged. The next run starts again with a continuation marker and then `FILL_SEED`.
- R6: Repeated dwords whose K-flag is not 4'b0001 are never compressed.
- R7: A valid received continuation marker sets the continuation state. It produces, one cycle later, a valid output equal to the last stored primitive, which is data 0 and K-flag 0 after reset.
- R8: While the continuation state is set, a valid received non-primitive dword produces no valid output.
- R9: A valid received primitive other than the marker clears the continuation state, becomes the stored primitive, and is output unchanged one cycle later.
- R10: Outside continuation, a valid received non-primitive dword is output unchanged one cycle later. An invalid input cycle gives `rx_out_valid` = 0 one cycle later.
- R11: A valid received HOLD primitive (data 32'hD5D5AA7C, K-flag 4'b0001) that arrives while the continuation state is set empties the transmit history. The transmit side then sends three more plain copies of a repeated primitive before its next continuation marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_in_data | input | 32 | Dword from the link layer |
| tx_in_k | input | 4 | K-flag of the link-layer dword |
| tx_out_data | output | 32 | Dword toward the PHY |
| tx_out_k | output | 4 | K-flag toward the PHY |
| rx_in_valid | input | 1 | Received dword is valid |
| rx_in_data | input | 32 | Dword from the PHY |
| rx_in_k | input | 4 | K-flag from the PHY |
| rx_out_valid | output | 1 | Restored dword is valid |
| rx_out_data | output | 32 | Restored dword toward the link layer |
| rx_out_k | output | 4 | K-flag of the restored dword |

## Verification
The hardest case to reach is the cross-direction reset of R11. It needs a HOLD to arrive on the receive side after a continuation marker, and at the same time a primitive run must already be compressed on the transmit side. A directed sequence holds one primitive on transmit for many cycles and sends marker, fillers and then HOLD on receive. The random phase keeps transmit runs long and weights marker and HOLD heavily on receive, so this collision happens again at many different points in a run.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int DW = 32;
  localparam int KW = 4;

  typedef struct packed {
    logic [DW-1:0] data;
    logic [KW-1:0] k;
  } word_t;

  localparam logic [KW-1:0] K_PRIM = 4'b0001;
  localparam logic [DW-1:0] CONT_W = 32'h9999AA7C;
  localparam logic [DW-1:0] HOLD_W = 32'hD5D5AA7C;

  function automatic logic is_prim(word_t w);
    return w.k == K_PRIM;
  endfunction

  function automatic logic is_word(word_t w, logic [DW-1:0] code);
    return (w.k == K_PRIM) && (w.data == code);
  endfunction
endpackage

// File: rtl/prc_filler_gen.sv
module prc_filler_gen #(
  parameter int W = 32,
  parameter logic [W-1:0] SEED = '1,
  parameter logic [W-1:0] POLY = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         advance,
  output logic [W-1:0] fill
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_nx;

  always_comb begin
    state_nx = state_q >> 1;
    if (state_q[0]) state_nx = state_nx ^ POLY;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) state_q <= SEED;
    else if (advance)   state_q <= state_nx;
  end

  assign fill = state_q;
endmodule

// File: rtl/prc_tx_compress.sv
module prc_tx_compress import prc_pkg::*; #(
  parameter int HIST_LEN = 3,
  parameter logic [DW-1:0] FILL_SEED = 32'hF0F6E3A1,
  parameter logic [DW-1:0] FILL_POLY = 32'h80200003
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  clr_hist,
  input  word_t in_w,
  output word_t out_w
);
  word_t        hist_q [HIST_LEN];
  word_t        out_q;
  logic         run_q;
  logic         rep;
  logic [DW-1:0] fill;

  always_comb begin
    rep = 1'b1;
    for (int i = 0; i < HIST_LEN; i++)
      if (!is_prim(hist_q[i]) || hist_q[i] != in_w) rep = 1'b0;
  end

  prc_filler_gen #(.W(DW), .SEED(FILL_SEED), .POLY(FILL_POLY)) filler_i (
    .clk(clk), .rst(rst), .restart(!rep), .advance(rep && run_q), .fill(fill)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      run_q <= 1'b0;
      for (int i = 0; i < HIST_LEN; i++) hist_q[i] <= '0;
    end else begin
      run_q <= rep;
      if (!rep)       out_q <= in_w;
      else if (run_q) out_q <= '{data: fill, k: '0};
      else            out_q <= '{data: CONT_W, k: K_PRIM};
      if (clr_hist) begin
        for (int i = 0; i < HIST_LEN; i++) hist_q[i] <= '0;
      end else begin
        for (int i = 0; i < HIST_LEN - 1; i++) hist_q[i] <= hist_q[i+1];
        hist_q[HIST_LEN-1] <= in_w;
      end
    end
  end

  assign out_w = out_q;

  // R3
  run_start_marker_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> (out_q.data == CONT_W && out_q.k == K_PRIM));
  // R6
  nonprim_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !is_prim(in_w) |=> (out_q == $past(in_w)));
endmodule

// File: rtl/prc_rx_expand.sv
module prc_rx_expand import prc_pkg::*; (
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  input  word_t in_w,
  output logic  out_valid,
  output word_t out_w,
  output logic  hold_in_cont
);
  logic  cont_q;
  word_t last_q;
  word_t out_q;
  logic  vld_q;

  assign hold_in_cont = in_valid && cont_q && is_word(in_w, HOLD_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      cont_q <= 1'b0;
      last_q <= '0;
      out_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (in_valid) begin
        if (is_word(in_w, CONT_W)) begin
          cont_q <= 1'b1;
          out_q  <= last_q;
          vld_q  <= 1'b1;
        end else if (is_prim(in_w)) begin
          cont_q <= 1'b0;
          last_q <= in_w;
          out_q  <= in_w;
          vld_q  <= 1'b1;
        end else if (!cont_q) begin
          out_q <= in_w;
          vld_q <= 1'b1;
        end
      end
    end
  end

  assign out_valid = vld_q;
  assign out_w     = out_q;

  // R8
  filler_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cont_q && !is_prim(in_w)) |=> !vld_q);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !vld_q);
  // R9
  prim_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_prim(in_w) && !is_word(in_w, CONT_W)) |=> !cont_q);
endmodule

// File: rtl/prim_run_codec.sv
module prim_run_codec import prc_pkg::*; #(
  parameter int HIST_LEN = 3,
  parameter logic [DW-1:0] FILL_SEED = 32'hF0F6E3A1,
  parameter logic [DW-1:0] FILL_POLY = 32'h80200003
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] tx_in_data,
  input  logic [KW-1:0] tx_in_k,
  output logic [DW-1:0] tx_out_data,
  output logic [KW-1:0] tx_out_k,
  input  logic          rx_in_valid,
  input  logic [DW-1:0] rx_in_data,
  input  logic [KW-1:0] rx_in_k,
  output logic          rx_out_valid,
  output logic [DW-1:0] rx_out_data,
  output logic [KW-1:0] rx_out_k
);
  word_t tx_o, rx_o;
  logic  clr_hist;

  prc_rx_expand rx_i (
    .clk(clk), .rst(rst), .in_valid(rx_in_valid),
    .in_w('{data: rx_in_data, k: rx_in_k}),
    .out_valid(rx_out_valid), .out_w(rx_o), .hold_in_cont(clr_hist)
  );

  prc_tx_compress #(.HIST_LEN(HIST_LEN), .FILL_SEED(FILL_SEED), .FILL_POLY(FILL_POLY)) tx_i (
    .clk(clk), .rst(rst), .clr_hist(clr_hist),
    .in_w('{data: tx_in_data, k: tx_in_k}), .out_w(tx_o)
  );

  assign tx_out_data = tx_o.data;
  assign tx_out_k    = tx_o.k;
  assign rx_out_data = rx_o.data;
  assign rx_out_k    = rx_o.k;
endmodule

// File: tb/prim_run_codec_tb_top.sv
module prim_run_codec_tb_top;
  localparam logic [31:0] SEED  = 32'hF0F6E3A1;
  localparam logic [31:0] POLY  = 32'h80200003;
  localparam logic [31:0] CONTD = 32'h9999AA7C;
  localparam logic [31:0] HOLDD = 32'hD5D5AA7C;
  localparam logic [31:0] PA    = 32'hB5B5957C;
  localparam logic [31:0] PB    = 32'h7E7EB57C;
  localparam logic [3:0]  KP    = 4'b0001;

  logic clk = 1'b0, rst = 1'b1;
  logic [31:0] tx_in_data = '0, rx_in_data = '0, tx_out_data, rx_out_data;
  logic [3:0]  tx_in_k = '0, rx_in_k = '0, tx_out_k, rx_out_k;
  logic rx_in_valid = 1'b0, rx_out_valid;

  always #4 clk = ~clk;

  prim_run_codec dut_i (
    .clk(clk), .rst(rst),
    .tx_in_data(tx_in_data), .tx_in_k(tx_in_k),
    .tx_out_data(tx_out_data), .tx_out_k(tx_out_k),
    .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data), .rx_in_k(rx_in_k),
    .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data), .rx_out_k(rx_out_k)
  );

  int total = 0, fails = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] h_d [3];
  logic [3:0]  h_k [3];
  logic m_run, m_cont, have_exp;
  logic [31:0] m_fill, m_last_d;
  logic [3:0]  m_last_k;
  int since_clr;
  logic [31:0] e_td, e_rd;
  logic [3:0]  e_tk, e_rk;
  logic e_rv;
  string t_tag, r_tag;

  function automatic logic [31:0] fnext(logic [31:0] s);
    return (s >> 1) ^ (s[0] ? POLY : 32'h0);
  endfunction

  task automatic chk(string tag, string what, logic [35:0] got, logic [35:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic model_reset;
    for (int i = 0; i < 3; i++) begin h_d[i] = '0; h_k[i] = '0; end
    m_run = 0; m_cont = 0; m_fill = SEED; m_last_d = '0; m_last_k = '0;
    since_clr = 99; have_exp = 0;
  endtask

  task automatic model_step;
    logic clr, rep, was_run;
    clr = rx_in_valid && m_cont && rx_in_k == KP && rx_in_data == HOLDD;
    e_rv = 0; e_rd = '0; e_rk = '0; r_tag = "R10";
    if (rx_in_valid) begin
      if (rx_in_k == KP && rx_in_data == CONTD) begin
        m_cont = 1; e_rv = 1; e_rd = m_last_d; e_rk = m_last_k; r_tag = "R7";
      end else if (rx_in_k == KP) begin
        m_cont = 0; m_last_d = rx_in_data; m_last_k = rx_in_k;
        e_rv = 1; e_rd = rx_in_data; e_rk = rx_in_k; r_tag = "R9";
      end else if (m_cont) begin
        r_tag = "R8";
      end else begin
        e_rv = 1; e_rd = rx_in_data; e_rk = rx_in_k;
      end
    end
    rep = 1;
    for (int i = 0; i < 3; i++)
      if (h_k[i] != KP || h_d[i] != tx_in_data || h_k[i] != tx_in_k) rep = 0;
    was_run = m_run;
    if (rep) begin
      if (m_run) begin e_td = m_fill; e_tk = '0; m_fill = fnext(m_fill); t_tag = "R4"; end
      else begin e_td = CONTD; e_tk = KP; t_tag = "R3"; end
      m_run = 1;
    end else begin
      e_td = tx_in_data; e_tk = tx_in_k; m_run = 0; m_fill = SEED;
      t_tag = (tx_in_k != KP) ? "R6" : (was_run ? "R5" : "R2");
    end
    if (since_clr < 5) t_tag = "R11";
    if (clr) begin
      for (int i = 0; i < 3; i++) begin h_d[i] = '0; h_k[i] = '0; end
      since_clr = 0;
    end else begin
      h_d[0] = h_d[1]; h_k[0] = h_k[1]; h_d[1] = h_d[2]; h_k[1] = h_k[2];
      h_d[2] = tx_in_data; h_k[2] = tx_in_k;
      if (since_clr < 99) since_clr++;
    end
    have_exp = 1;
  endtask

  // one cycle: compare previous expectation, then drive and predict
  task automatic cyc(logic [31:0] td, logic [3:0] tk, logic rv, logic [31:0] rd, logic [3:0] rk);
    @(negedge clk);
    if (have_exp) begin
      chk(t_tag, "tx", {tx_out_data, tx_out_k}, {e_td, e_tk});
      chk(r_tag, "rx_valid", {35'd0, rx_out_valid}, {35'd0, e_rv});
      if (e_rv) chk(r_tag, "rx", {rx_out_data, rx_out_k}, {e_rd, e_rk});
    end
    tx_in_data = td; tx_in_k = tk; rx_in_valid = rv; rx_in_data = rd; rx_in_k = rk;
    model_step();
  endtask

  initial begin
    logic [31:0] td, rd;
    logic [3:0] tk, rk;
    logic rv;
    int r;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "tx", {tx_out_data, tx_out_k}, 36'd0);
    chk("R1", "rx_valid", {35'd0, rx_out_valid}, 36'd0);
    rst = 1'b0;
    // R7 before any primitive: marker restores zero
    cyc(32'h11, 0, 1, CONTD, KP);
    cyc(32'h22, 0, 1, 32'h5, 0);
    // directed run: R3, R4, then R5
    for (int i = 0; i < 10; i++) cyc(PA, KP, 1, PB, KP);
    cyc(32'hDEAD, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) cyc(PA, KP, 1, 32'h1234 + i, 0);
    // R6: repeated non-primitive
    for (int i = 0; i < 6; i++) cyc(32'hCAFE, 4'b0000, 0, 0, 0);
    for (int i = 0; i < 6; i++) cyc(PB, 4'b0011, 0, 0, 0);
    // R11 directed: long tx run, rx marker, fillers, HOLD
    for (int i = 0; i < 8; i++) cyc(PA, KP, 1, PB, KP);
    cyc(PA, KP, 1, CONTD, KP);
    cyc(PA, KP, 1, 32'h777, 0);
    cyc(PA, KP, 1, HOLDD, KP);
    for (int i = 0; i < 8; i++) cyc(PA, KP, 1, 32'h888, 0);
    // random phase
    td = PA; tk = KP;
    for (int n = 0; n < 4000; n++) begin
      r = $urandom_range(0, 99);
      if (r >= 75) begin
        r = $urandom_range(0, 3);
        case (r)
          0: begin td = PA; tk = KP; end
          1: begin td = HOLDD; tk = KP; end
          2: begin td = $urandom; tk = 0; end
          default: begin td = PB; tk = KP; end
        endcase
      end
      r = $urandom_range(0, 99);
      rv = (r >= 12);
      r = $urandom_range(0, 99);
      if (r < 22)      begin rd = CONTD; rk = KP; end
      else if (r < 35) begin rd = HOLDD; rk = KP; end
      else if (r < 47) begin rd = (r[0] ? PA : PB); rk = KP; end
      else             begin rd = $urandom; rk = 0; end
      cyc(td, tk, rv, rd, rk);
    end
    cyc(0, 0, 0, 0, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule